// File: doc/BRIEF.md
# Command/Response Exchange Sequencer

This block runs one complete command exchange with a security module that exposes a status register and a data FIFO. On a start pulse it checks that the length field in the command header agrees with the length the caller supplied. It then tells the module that a command is coming and hands the command bytes to a burst chunker. Next it writes the execute bit and polls the status register at a programmable interval until the response is ready, or until a timeout expires.

It then reads the response in three parts. The 6-byte header comes first, because its size field gives the total length. Then it reads everything except the last byte through the chunker, and finally the last byte on its own. Status is read just before and just after that last byte, so that the data-available flag can be seen set and then cleared. The exchange ends by writing the command-ready bit again, which puts the module back into its idle state.

Register accesses go out through a framer request port. Multi-byte FIFO moves go out through a chunker request port. Each request is held until its target pulses done. The 4-byte big-endian size fields are fetched one byte at a time through a byte lookup port into the caller's command or response buffer. The block ends every exchange with either a one-cycle done pulse carrying the response length, or a one-cycle error pulse with a code that names the failed step.

Top module: `xchg_seq`

## Requirements
- R1: After reset, fr_req, ck_req, done and err are all low, and both request ports stay idle until start is pulsed.
- R2: Bytes 2 to 5 of the command (buf_sel=0), taken as a big-endian 32-bit value, must equal cmd_len. On a mismatch, err pulses with err_code 1 and no framer or chunker request is issued.
- R3: The first request of an exchange is a framer status write (fr_wr=1, fr_fifo=0) of 0x40, with bit 6 set. It is followed by one chunker transmit request (ck_rx=0) with offset 0 and length cmd_len.
- R4: After the command has been sent, a status write of 0x20 (bit 5) starts execution.
- R5: The block polls with status reads (fr_wr=0, fr_fifo=0). Consecutive polls start at least poll_gap cycles apart. Polling ends when the read value has bit 7 and bit 4 both set.
- R6: If that condition is not seen within TIMEOUT_CYCLES cycles of the execute write, err pulses with err_code 2 and no further write is issued.
- R7: The response header is fetched as a FIFO read (fr_fifo=1) of length 6 at offset 0. Its bytes 2 to 5 (buf_sel=1), taken big-endian, give the total length. A total above max_rsp gives err_code 3, and a total below 7 gives err_code 4. A total equal to max_rsp is accepted.
- R8: The body is a chunker receive (ck_rx=1) with offset 6 and length total-7, and it is skipped when that length is 0. A status read follows, and it must show bits 7 and 4 set, otherwise err_code 5. Then comes a FIFO read of length 1 at offset total-1.
- R9: After the last byte, a status read must show bit 7 set and bit 4 clear, otherwise err_code 6 and no idle write is issued.
- R10: On success, a final status write of 0x40 is issued, then done pulses for one cycle with rsp_len equal to the total length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an exchange (accepted when idle) |
| cmd_len | input | LEN_W | Caller-supplied command length in bytes |
| max_rsp | input | LEN_W | Largest response the sink can hold |
| poll_gap | input | GAP_W | Idle cycles between status polls |
| buf_sel | output | 1 | Byte lookup target: 0 command buffer, 1 response buffer |
| buf_idx | output | 3 | Byte index for the lookup (2 to 5) |
| buf_byte | input | 8 | Looked-up byte, valid in the same cycle |
| ck_req | output | 1 | Chunker request, held until ck_done |
| ck_rx | output | 1 | Chunker direction: 1 receive, 0 transmit |
| ck_off | output | LEN_W | Buffer offset for the chunker move |
| ck_len | output | LEN_W | Byte count for the chunker move |
| ck_done | input | 1 | Chunker completion pulse |
| fr_req | output | 1 | Framer request, held until fr_done |
| fr_wr | output | 1 | Framer write (1) or read (0) |
| fr_fifo | output | 1 | Target: 1 data FIFO, 0 status register |
| fr_off | output | LEN_W | Response buffer offset for FIFO reads |
| fr_len | output | 7 | Transfer length in bytes |
| fr_wdata | output | 32 | Status value for writes |
| fr_done | input | 1 | Framer completion pulse |
| fr_rdata | input | 32 | Status value returned with fr_done |
| done | output | 1 | One-cycle success pulse |
| err | output | 1 | One-cycle failure pulse |
| err_code | output | 3 | Failed step, held until the next start |
| rsp_len | output | LEN_W | Response length, valid with done |

## Verification
The bench builds the block with TIMEOUT_CYCLES set to 300 and LEN_W left at 12. The short timeout lets a module that never becomes ready trigger the timeout error in a few hundred cycles. That run also checks poll spacing and the number of polls against the programmed gap of 10. With LEN_W at 12, the response sizes used in the tests fit in the length fields. This covers the empty-body total of 7, a total exactly equal to the caller's maximum, totals just outside either limit, and an oversized total, each in its own exchange.

// File: rtl/xchg_pkg.sv
// Shared encodings for the exchange sequencer: FSM states, error codes,
// and the status-register bit positions the sequence depends on.
package xchg_pkg;

    localparam int ST_VALID_BIT = 7;
    localparam int ST_READY_BIT = 6;
    localparam int ST_GO_BIT    = 5;
    localparam int ST_AVAIL_BIT = 4;

    localparam logic [31:0] STS_READY_W = 32'(1) << ST_READY_BIT;
    localparam logic [31:0] STS_GO_W    = 32'(1) << ST_GO_BIT;
    localparam logic [31:0] STS_VALID   = 32'(1) << ST_VALID_BIT;
    localparam logic [31:0] STS_POLL_M  = STS_VALID | (32'(1) << ST_AVAIL_BIT);

    localparam int HDR_BYTES = 6;

    typedef enum logic [3:0] {
        S_IDLE, S_CLEN, S_CCHK, S_RDY,  S_SEND, S_GO,   S_WAIT, S_POLL,
        S_HDR,  S_RLEN, S_RCHK, S_BODY, S_PRE,  S_LAST, S_POST, S_FIN
    } state_t;

    typedef enum logic [2:0] {
        E_NONE      = 3'd0,
        E_CMD_LEN   = 3'd1,
        E_TIMEOUT   = 3'd2,
        E_RSP_BIG   = 3'd3,
        E_RSP_SHORT = 3'd4,
        E_PRE_STS   = 3'd5,
        E_POST_STS  = 3'd6
    } err_t;

endpackage

// File: rtl/xchg_be_gather.sv
// Assembles a big-endian 32-bit size field from four single-byte lookups.
// Assumes the looked-up byte is valid in the same cycle as the index.
// After a start pulse it walks indices 0..3 and then raises rdy for one
// cycle; word holds the value until the next start.
module xchg_be_gather (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       start,
    input  logic [7:0] byte_in,
    output logic [1:0] idx,
    output logic       rdy,
    output logic [31:0] word
);
    logic busy;
    logic [1:0] cnt;

    assign idx = cnt;

    // Shift one byte per cycle, most significant first.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            cnt  <= '0;
            rdy  <= 1'b0;
            word <= '0;
        end else begin
            rdy <= 1'b0;
            if (start) begin
                busy <= 1'b1;
                cnt  <= '0;
            end else if (busy) begin
                word <= {word[23:0], byte_in};
                cnt  <= cnt + 2'd1;
                if (cnt == 2'd3) begin
                    busy <= 1'b0;
                    rdy  <= 1'b1;
                end
            end
        end
    end

    assert_rdy_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rdy |=> !rdy);

endmodule

// File: rtl/xchg_poll_timer.sv
// Poll interval and timeout counters for the completion wait.
// arm clears the timeout and loads the interval; rearm reloads the interval.
// The timeout counter runs while run is high and saturates at TIMEOUT_CYCLES.
module xchg_poll_timer #(
    parameter int GAP_W          = 16,
    parameter int TIMEOUT_CYCLES = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             arm,
    input  logic             rearm,
    input  logic             run,
    input  logic             count_gap,
    input  logic [GAP_W-1:0] gap,
    output logic             due,
    output logic             expired
);
    localparam int TMO_W = $clog2(TIMEOUT_CYCLES + 1);
    localparam logic [TMO_W-1:0] TMO_MAX = TMO_W'(TIMEOUT_CYCLES);

    logic [GAP_W-1:0] gap_cnt;
    logic [TMO_W-1:0] tmo_cnt;

    assign due     = (gap_cnt == '0);
    assign expired = (tmo_cnt == TMO_MAX);

    // Interval countdown between polls.
    always_ff @(posedge clk) begin
        if (!rst_n)                    gap_cnt <= '0;
        else if (arm || rearm)         gap_cnt <= gap;
        else if (count_gap && !due)    gap_cnt <= gap_cnt - 1'b1;
    end

    // Saturating elapsed-time counter since the execute write.
    always_ff @(posedge clk) begin
        if (!rst_n)                    tmo_cnt <= '0;
        else if (arm)                  tmo_cnt <= '0;
        else if (run && !expired)      tmo_cnt <= tmo_cnt + 1'b1;
    end

    assert_tmo_cap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        tmo_cnt <= TMO_MAX);
    assert_tmo_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !arm) |=> expired);

endmodule

// File: rtl/xchg_seq.sv
// Command/response exchange sequencer for a FIFO-interface security module.
// Drives the status register and data FIFO through a framer port and bulk
// moves through a chunker port; each request is held until its done pulse.
// Assumes LEN_W < 32 and that a start arriving during an exchange is ignored.
module xchg_seq
    import xchg_pkg::*;
#(
    parameter int LEN_W          = 12,
    parameter int GAP_W          = 16,
    parameter int TIMEOUT_CYCLES = 1000000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [LEN_W-1:0] cmd_len,
    input  logic [LEN_W-1:0] max_rsp,
    input  logic [GAP_W-1:0] poll_gap,
    output logic             buf_sel,
    output logic [2:0]       buf_idx,
    input  logic [7:0]       buf_byte,
    output logic             ck_req,
    output logic             ck_rx,
    output logic [LEN_W-1:0] ck_off,
    output logic [LEN_W-1:0] ck_len,
    input  logic             ck_done,
    output logic             fr_req,
    output logic             fr_wr,
    output logic             fr_fifo,
    output logic [LEN_W-1:0] fr_off,
    output logic [6:0]       fr_len,
    output logic [31:0]      fr_wdata,
    input  logic             fr_done,
    input  logic [31:0]      fr_rdata,
    output logic             done,
    output logic             err,
    output logic [2:0]       err_code,
    output logic [LEN_W-1:0] rsp_len
);
    localparam logic [LEN_W-1:0] HDR_L  = LEN_W'(HDR_BYTES);
    localparam logic [LEN_W-1:0] MIN_L  = LEN_W'(HDR_BYTES + 1);
    localparam logic [31:0]      MIN_W  = 32'(HDR_BYTES + 1);

    state_t           state;
    logic [LEN_W-1:0] tot_l;
    logic             g_start, g_rdy;
    logic [1:0]       g_idx;
    logic [31:0]      g_word;
    logic             t_arm, t_rearm, t_due, t_exp;

    xchg_be_gather u_gather (
        .clk(clk), .rst_n(rst_n), .start(g_start), .byte_in(buf_byte),
        .idx(g_idx), .rdy(g_rdy), .word(g_word)
    );

    xchg_poll_timer #(.GAP_W(GAP_W), .TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .arm(t_arm), .rearm(t_rearm),
        .run(state == S_WAIT || state == S_POLL), .count_gap(state == S_WAIT),
        .gap(poll_gap), .due(t_due), .expired(t_exp)
    );

    // Control strobes for the size-field gatherer and the poll timer.
    always_comb begin
        g_start = (state == S_IDLE && start) || (state == S_HDR && fr_done);
        t_arm   = (state == S_GO && fr_done);
        t_rearm = (state == S_POLL && fr_done);
        buf_sel = (state == S_RLEN);
        buf_idx = 3'd2 + {1'b0, g_idx};
    end

    // Request port decode from the current step.
    always_comb begin
        ck_req   = (state == S_SEND) || (state == S_BODY);
        ck_rx    = (state == S_BODY);
        ck_off   = (state == S_BODY) ? HDR_L : '0;
        ck_len   = (state == S_BODY) ? (tot_l - MIN_L) : cmd_len;
        fr_req   = 1'b0;
        fr_wr    = 1'b0;
        fr_fifo  = 1'b0;
        fr_off   = '0;
        fr_len   = 7'd4;
        fr_wdata = '0;
        case (state)
            S_RDY, S_FIN: begin fr_req = 1'b1; fr_wr = 1'b1; fr_wdata = STS_READY_W; end
            S_GO:         begin fr_req = 1'b1; fr_wr = 1'b1; fr_wdata = STS_GO_W; end
            S_POLL, S_PRE, S_POST: fr_req = 1'b1;
            S_HDR:        begin fr_req = 1'b1; fr_fifo = 1'b1; fr_len = 7'(HDR_BYTES); end
            S_LAST:       begin fr_req = 1'b1; fr_fifo = 1'b1; fr_len = 7'd1;
                                fr_off = tot_l - 1'b1; end
            default: ;
        endcase
    end

    // Exchange sequence, result pulses and held result fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= S_IDLE;
            tot_l    <= '0;
            done     <= 1'b0;
            err      <= 1'b0;
            err_code <= E_NONE;
            rsp_len  <= '0;
        end else begin
            done <= 1'b0;
            err  <= 1'b0;
            case (state)
                S_IDLE: if (start) begin state <= S_CLEN; err_code <= E_NONE; end
                S_CLEN: if (g_rdy) state <= S_CCHK;
                S_CCHK: begin
                    if (g_word != 32'(cmd_len)) begin
                        state <= S_IDLE; err <= 1'b1; err_code <= E_CMD_LEN;
                    end else state <= S_RDY;
                end
                S_RDY:  if (fr_done) state <= S_SEND;
                S_SEND: if (ck_done) state <= S_GO;
                S_GO:   if (fr_done) state <= S_WAIT;
                S_WAIT: begin
                    if (t_exp) begin
                        state <= S_IDLE; err <= 1'b1; err_code <= E_TIMEOUT;
                    end else if (t_due) state <= S_POLL;
                end
                S_POLL: if (fr_done)
                    state <= ((fr_rdata & STS_POLL_M) == STS_POLL_M) ? S_HDR : S_WAIT;
                S_HDR:  if (fr_done) state <= S_RLEN;
                S_RLEN: if (g_rdy) state <= S_RCHK;
                S_RCHK: begin
                    if (g_word > 32'(max_rsp)) begin
                        state <= S_IDLE; err <= 1'b1; err_code <= E_RSP_BIG;
                    end else if (g_word < MIN_W) begin
                        state <= S_IDLE; err <= 1'b1; err_code <= E_RSP_SHORT;
                    end else begin
                        tot_l <= g_word[LEN_W-1:0];
                        state <= (g_word == MIN_W) ? S_PRE : S_BODY;
                    end
                end
                S_BODY: if (ck_done) state <= S_PRE;
                S_PRE:  if (fr_done) begin
                    if ((fr_rdata & STS_POLL_M) == STS_POLL_M) state <= S_LAST;
                    else begin state <= S_IDLE; err <= 1'b1; err_code <= E_PRE_STS; end
                end
                S_LAST: if (fr_done) state <= S_POST;
                S_POST: if (fr_done) begin
                    if ((fr_rdata & STS_POLL_M) == STS_VALID) state <= S_FIN;
                    else begin state <= S_IDLE; err <= 1'b1; err_code <= E_POST_STS; end
                end
                S_FIN:  if (fr_done) begin
                    state <= S_IDLE; done <= 1'b1; rsp_len <= tot_l;
                end
                default: state <= S_IDLE;
            endcase
        end
    end

    assert_one_target_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(fr_req && ck_req));
    assert_done_err_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !(done && err));
    assert_done_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    assert_err_code_R2: assert property (@(posedge clk) disable iff (!rst_n)
        err |-> (err_code != E_NONE));
    assert_cmd_match_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_RDY) |-> (g_word == 32'(cmd_len)));
    assert_body_fits_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ck_req && ck_rx) |-> (tot_l <= max_rsp && tot_l > MIN_L));
    assert_done_len_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (rsp_len >= MIN_L && rsp_len <= max_rsp));

endmodule

// File: tb/tb_xchg_seq.sv
// Directed bench: a behavioural framer/chunker/module model answers the
// sequencer's requests and logs them; each scenario task checks its results.
module tb_xchg_seq;
    localparam int CLK_PERIOD = 10;
    localparam int LEN_W = 12;
    localparam int GAP_W = 16;
    localparam int TMO   = 300;
    localparam int GAP   = 10;
    localparam int LAT   = 2;

    logic clk = 1'b0, rst_n = 1'b0, start = 1'b0;
    logic [LEN_W-1:0] cmd_len = '0, max_rsp = '0;
    logic [GAP_W-1:0] poll_gap = GAP_W'(GAP);
    logic buf_sel; logic [2:0] buf_idx; logic [7:0] buf_byte;
    logic ck_req, ck_rx, ck_done = 1'b0; logic [LEN_W-1:0] ck_off, ck_len;
    logic fr_req, fr_wr, fr_fifo, fr_done = 1'b0; logic [LEN_W-1:0] fr_off;
    logic [6:0] fr_len; logic [31:0] fr_wdata, fr_rdata = '0;
    logic done, err; logic [2:0] err_code; logic [LEN_W-1:0] rsp_len;

    logic [7:0] cmd_mem [0:7];
    logic [7:0] rsp_mem [0:7];
    assign buf_byte = buf_sel ? rsp_mem[buf_idx] : cmd_mem[buf_idx];

    xchg_seq #(.LEN_W(LEN_W), .GAP_W(GAP_W), .TIMEOUT_CYCLES(TMO)) dut (
        .clk(clk), .rst_n(rst_n), .start(start), .cmd_len(cmd_len),
        .max_rsp(max_rsp), .poll_gap(poll_gap), .buf_sel(buf_sel),
        .buf_idx(buf_idx), .buf_byte(buf_byte), .ck_req(ck_req), .ck_rx(ck_rx),
        .ck_off(ck_off), .ck_len(ck_len), .ck_done(ck_done), .fr_req(fr_req),
        .fr_wr(fr_wr), .fr_fifo(fr_fifo), .fr_off(fr_off), .fr_len(fr_len),
        .fr_wdata(fr_wdata), .fr_done(fr_done), .fr_rdata(fr_rdata),
        .done(done), .err(err), .err_code(err_code), .rsp_len(rsp_len)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int n_chk = 0, n_fail = 0;
    longint cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    // Model state and request logs.
    int ready_after = 0; bit pre_fault = 0, post_fault = 0;
    bit hdr_done = 0, last_done = 0;
    int n_req = 0, n_wr = 0, n_poll = 0, n_hdr = 0, n_last = 0, n_tx = 0, n_rx = 0;
    logic [31:0] wr_log [0:7];
    longint poll_t [0:63];
    int hdr_off, hdr_len, last_off, last_len, tx_off, tx_len, rx_off, rx_len;
    bit done_seen = 0, err_seen = 0; int seen_code = 0, seen_len = 0;

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Responder: answers one held request at a time after LAT cycles.
    initial begin
        forever begin
            @(negedge clk);
            if (fr_req || ck_req) begin
                logic [31:0] rd;
                bit av;
                rd = '0;
                n_req++;
                if (fr_req) begin
                    if (fr_wr) begin
                        if (n_wr < 8) wr_log[n_wr] = fr_wdata;
                        n_wr++;
                    end else if (fr_fifo) begin
                        if (fr_len == 7'd6) begin
                            hdr_off = int'(fr_off); hdr_len = int'(fr_len); n_hdr++; hdr_done = 1;
                        end else begin
                            last_off = int'(fr_off); last_len = int'(fr_len); n_last++; last_done = 1;
                        end
                    end else begin
                        if (last_done)     av = post_fault;
                        else if (hdr_done) av = !pre_fault;
                        else begin
                            av = (n_poll >= ready_after);
                            if (n_poll < 64) poll_t[n_poll] = cyc;
                            n_poll++;
                        end
                        rd = 32'h80 | (32'(av) << 4);
                    end
                end else begin
                    if (ck_rx) begin rx_off = int'(ck_off); rx_len = int'(ck_len); n_rx++; end
                    else       begin tx_off = int'(ck_off); tx_len = int'(ck_len); n_tx++; end
                end
                repeat (LAT) @(negedge clk);
                fr_rdata = rd;
                if (fr_req) fr_done = 1'b1; else ck_done = 1'b1;
                @(negedge clk);
                fr_done = 1'b0; ck_done = 1'b0;
            end
        end
    end

    // Result monitor sampled away from the active edge.
    initial begin
        forever begin
            @(negedge clk);
            if (done) begin done_seen = 1; seen_len = int'(rsp_len); end
            if (err)  begin err_seen = 1;  seen_code = int'(err_code); end
        end
    end

    task automatic run_xchg(input int enc_cmd, input int clen, input int total,
                            input int maxr, input int rdy_after, input bit pref, input bit postf);
        for (int i = 0; i < 4; i++) begin
            cmd_mem[2+i] = 8'(enc_cmd >> (8*(3-i)));
            rsp_mem[2+i] = 8'(total >> (8*(3-i)));
        end
        cmd_len = LEN_W'(clen); max_rsp = LEN_W'(maxr);
        ready_after = rdy_after; pre_fault = pref; post_fault = postf;
        hdr_done = 0; last_done = 0; n_req = 0; n_wr = 0; n_poll = 0; n_hdr = 0;
        n_last = 0; n_tx = 0; n_rx = 0; done_seen = 0; err_seen = 0;
        seen_code = 0; seen_len = 0;
        @(negedge clk); start = 1'b1;
        @(negedge clk); start = 1'b0;
        for (int w = 0; w < 5000 && !done_seen && !err_seen; w++) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset;
        chk(!fr_req && !ck_req, "R1 requests idle", fr_req + ck_req, 0);
        chk(!done && !err, "R1 results low", done + err, 0);
        repeat (5) @(negedge clk);
        chk(n_req == 0, "R1 no request before start", n_req, 0);
    endtask

    task automatic t_normal;
        run_xchg(12, 12, 20, 64, 3, 0, 0);
        chk(done_seen && !err_seen, "R10 done pulse", done_seen, 1);
        chk(seen_len == 20, "R10 rsp_len", seen_len, 20);
        chk(n_wr == 3, "R10 write count", n_wr, 3);
        chk(wr_log[0] == 32'h40, "R3 ready write", wr_log[0], 32'h40);
        chk(wr_log[1] == 32'h20, "R4 go write", wr_log[1], 32'h20);
        chk(wr_log[2] == 32'h40, "R10 idle write", wr_log[2], 32'h40);
        chk(n_tx == 1 && tx_off == 0 && tx_len == 12, "R3 command chunk len", tx_len, 12);
        chk(n_poll == 4, "R5 poll count", n_poll, 4);
        for (int i = 1; i < 4; i++)
            chk(poll_t[i] - poll_t[i-1] >= GAP, "R5 poll spacing", poll_t[i] - poll_t[i-1], GAP);
        chk(n_hdr == 1 && hdr_off == 0 && hdr_len == 6, "R7 header read", hdr_len, 6);
        chk(n_rx == 1 && rx_off == 6 && rx_len == 13, "R8 body chunk len", rx_len, 13);
        chk(n_last == 1 && last_off == 19 && last_len == 1, "R8 last byte offset", last_off, 19);
    endtask

    task automatic t_cmd_mismatch;
        run_xchg(13, 12, 20, 64, 0, 0, 0);
        chk(err_seen && seen_code == 1, "R2 length mismatch code", seen_code, 1);
        chk(n_req == 0, "R2 no requests", n_req, 0);
    endtask

    task automatic t_timeout;
        run_xchg(8, 8, 20, 64, 1000, 0, 0);
        chk(err_seen && seen_code == 2, "R6 timeout code", seen_code, 2);
        chk(n_wr == 2, "R6 no write after timeout", n_wr, 2);
        chk(n_poll >= 2 && n_poll <= TMO / GAP + 1, "R5 polls bounded by gap", n_poll, TMO / GAP);
        chk(n_hdr == 0, "R6 no header read", n_hdr, 0);
    endtask

    task automatic t_too_big;
        run_xchg(8, 8, 65, 64, 0, 0, 0);
        chk(err_seen && seen_code == 3, "R7 oversize code", seen_code, 3);
        chk(n_rx == 0 && n_last == 0, "R7 no body read", n_rx + n_last, 0);
    endtask

    task automatic t_too_short;
        run_xchg(8, 8, 6, 64, 0, 0, 0);
        chk(err_seen && seen_code == 4, "R7 short code", seen_code, 4);
    endtask

    task automatic t_min_total;
        run_xchg(8, 8, 7, 64, 0, 0, 0);
        chk(done_seen && seen_len == 7, "R8 empty body done", seen_len, 7);
        chk(n_rx == 0, "R8 body chunk skipped", n_rx, 0);
        chk(last_off == 6, "R8 last byte at 6", last_off, 6);
    endtask

    task automatic t_exact_max;
        run_xchg(10, 10, 64, 64, 2, 0, 0);
        chk(done_seen && seen_len == 64, "R7 total equal to max accepted", seen_len, 64);
        chk(rx_len == 57, "R8 body length at max", rx_len, 57);
    endtask

    task automatic t_pre_fault;
        run_xchg(8, 8, 20, 64, 0, 1, 0);
        chk(err_seen && seen_code == 5, "R8 pre-status code", seen_code, 5);
        chk(n_last == 0, "R8 last byte not read", n_last, 0);
    endtask

    task automatic t_post_fault;
        run_xchg(8, 8, 20, 64, 0, 0, 1);
        chk(err_seen && seen_code == 6, "R9 post-status code", seen_code, 6);
        chk(n_wr == 2, "R9 no idle write", n_wr, 2);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    initial begin
        for (int i = 0; i < 8; i++) begin cmd_mem[i] = 8'h00; rsp_mem[i] = 8'h00; end
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_normal();
        t_cmd_mismatch();
        t_timeout();
        t_too_big();
        t_too_short();
        t_min_total();
        t_exact_max();
        t_pre_fault();
        t_post_fault();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

endmodule